// File: doc/BRIEF.md
# Resizable Issue Queue with Gated Wakeup Comparators

This block holds instructions that are waiting for their operands. It is a circular queue: new instructions are written at the tail and retired from the head. Each slot stores an opcode, a destination tag, and two source tags, each with its own ready flag. When execution broadcasts a result tag, every waiting operand that is still not ready compares its source tag against it. A match sets that operand's ready flag. A slot with both operands ready asks to issue. A simple picker grants the oldest requesting slot, one per cycle.

Energy is saved in two ways. First, a comparator is switched off when its slot is empty, when its slot has already issued, or when its operand is already ready. The number of comparators switched on is brought out as a count. Second, an effective size caps how many slots dispatch may fill. A monitor counts retirements over fixed windows of cycles. The size shrinks in fixed steps while a window's count stays below a threshold. It grows again after a run of windows at or above that threshold. The size never drops below a floor or below the current occupancy.

Functional units, the register file and rename sit outside the block. In the surrounding pipeline, dispatch writes to the queue, execution broadcasts result tags, and retirement pulses the commit input.

Top module: `gated_issue_queue`

## Requirements
- R1: After reset the queue is empty (`q_count` = 0), `eff_size` equals DEPTH, `iss_valid` is 0 and `disp_ready` is 1.
- R2: `disp_ready` is 1 exactly when `q_count` < `eff_size`. A dispatch offered while `disp_ready` is 0 is dropped, and `q_count` does not grow.
- R3: When `bc_valid` is high and `bc_tag` equals the source tag of a waiting, not-ready operand, that operand becomes ready at the clock edge. A slot with both operands ready requests issue in the following cycle.
- R4: `cmp_active` is 0 when `bc_valid` is low. Otherwise it equals the number of not-ready operands in occupied, unissued slots. A slot written in the same cycle as a broadcast is not compared against that broadcast.
- R5: `iss_valid` is high whenever some occupied, unissued slot has both operands ready. `iss_op` and `iss_dst` then show the oldest such slot in dispatch order, which is marked issued at the edge. At most one slot issues per cycle.
- R6: `commit` retires the head slot only when that slot has issued. A commit against an unissued head is ignored.
- R7: Every WIN_CYC cycles the window closes. The commit count includes the closing cycle. If the count is below THRESH, `eff_size` drops by STEP, but not below MIN_SIZE and not below the occupancy left after that cycle.
- R8: If GROW_PERIODS consecutive windows each reach at least THRESH commits, `eff_size` rises by STEP, capped at DEPTH, and the run starts over. A low window resets the run.
- R9: `eff_size` changes only at the edge that closes a window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| disp_valid | input | 1 | Dispatch offer |
| disp_op | input | OP_W | Opcode of offered instruction |
| disp_dst | input | TAG_W | Destination tag |
| disp_s1 | input | TAG_W | First source tag |
| disp_r1 | input | 1 | First source already ready |
| disp_s2 | input | TAG_W | Second source tag |
| disp_r2 | input | 1 | Second source already ready |
| disp_ready | output | 1 | Queue accepts a dispatch this cycle |
| bc_valid | input | 1 | Result tag broadcast valid |
| bc_tag | input | TAG_W | Broadcast result tag |
| commit | input | 1 | Retire request for the head slot |
| iss_valid | output | 1 | A slot is issuing this cycle |
| iss_op | output | OP_W | Opcode of issuing slot |
| iss_dst | output | TAG_W | Destination tag of issuing slot |
| q_count | output | $clog2(DEPTH+1) | Occupied slots |
| eff_size | output | $clog2(DEPTH+1) | Current effective size |
| cmp_active | output | $clog2(2*DEPTH+1) | Tag comparators enabled this cycle |

## Verification
A wrong ready flag or issued mark shows up at the ports in one of two ways. The issue order can differ from oldest-ready, or an issue can be missing or repeated, and either appears in the cycle after the broadcast or dispatch that should have caused it. A comparator left on or off wrongly changes `cmp_active` in the same cycle as the broadcast, even when no wakeup results. A fault in the window counters or in the size arithmetic appears on `eff_size` right after a window closes. The bench checks it every cycle, so a late or early change is caught at the exact edge.

// File: rtl/giq_pkg.sv
`timescale 1ns/1ps
package giq_pkg;
  typedef enum logic [1:0] {SZ_HOLD, SZ_SHRINK, SZ_GROW} size_act_e;

  // smaller size, held above both the floor and the live occupancy
  function automatic int shrink_size(int cur, int occ, int step, int floor_sz);
    int n;
    n = cur - step;
    if (n < floor_sz) n = floor_sz;
    if (n < occ) n = occ;
    return n;
  endfunction

  // larger size, held at or below the physical capacity
  function automatic int grow_size(int cur, int step, int cap);
    int n;
    n = cur + step;
    if (n > cap) n = cap;
    return n;
  endfunction
endpackage

// File: rtl/giq_slot.sv
`timescale 1ns/1ps
module giq_slot #(
  parameter int OP_W  = 6,
  parameter int TAG_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [OP_W-1:0]  wr_op,
  input  logic [TAG_W-1:0] wr_dst,
  input  logic [TAG_W-1:0] wr_s1,
  input  logic             wr_r1,
  input  logic [TAG_W-1:0] wr_s2,
  input  logic             wr_r2,
  input  logic             clr,
  input  logic             iss_set,
  input  logic             bc_valid,
  input  logic [TAG_W-1:0] bc_tag,
  output logic             busy,
  output logic             done,
  output logic             req,
  output logic [1:0]       cmp_on,
  output logic [OP_W-1:0]  op,
  output logic [TAG_W-1:0] dst
);
  logic             v_q, d_q;
  logic [OP_W-1:0]  op_q;
  logic [TAG_W-1:0] dst_q;
  logic [TAG_W-1:0] src_q [2];
  logic [1:0]       rdy_q;
  logic [1:0]       hit;

  always_comb begin
    for (int k = 0; k < 2; k++) begin
      cmp_on[k] = bc_valid && v_q && !d_q && !rdy_q[k];
      hit[k]    = cmp_on[k] && (src_q[k] == bc_tag);
    end
  end

  assign busy = v_q;
  assign done = d_q;
  assign req  = v_q && !d_q && (rdy_q == 2'b11);
  assign op   = op_q;
  assign dst  = dst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q      <= 1'b0;
      d_q      <= 1'b0;
      op_q     <= '0;
      dst_q    <= '0;
      src_q[0] <= '0;
      src_q[1] <= '0;
      rdy_q    <= '0;
    end else if (wr_en) begin
      v_q      <= 1'b1;
      d_q      <= 1'b0;
      op_q     <= wr_op;
      dst_q    <= wr_dst;
      src_q[0] <= wr_s1;
      src_q[1] <= wr_s2;
      rdy_q    <= {wr_r2, wr_r1};
    end else begin
      if (clr) begin
        v_q <= 1'b0;
        d_q <= 1'b0;
      end
      if (iss_set) d_q <= 1'b1;
      rdy_q <= rdy_q | hit;
    end
  end

  // R3
  rdy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (v_q && rdy_q[0] && !wr_en) |=> rdy_q[0]);
  // R5
  iss_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    iss_set |-> (v_q && !d_q && rdy_q == 2'b11));
  // R4
  gate_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (v_q && d_q && !wr_en) |=> $stable(rdy_q));
endmodule

// File: rtl/giq_pick.sv
`timescale 1ns/1ps
module giq_pick #(
  parameter int DEPTH = 128,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic [DEPTH-1:0] req,
  input  logic [IDX_W-1:0] head,
  output logic             any,
  output logic [IDX_W-1:0] idx,
  output logic [DEPTH-1:0] grant
);
  logic [2*DEPTH-1:0] dbl;
  logic [DEPTH-1:0]   rot;
  logic [IDX_W-1:0]   off;

  always_comb begin
    dbl = {req, req};
    rot = dbl[head +: DEPTH];
    any = 1'b0;
    off = '0;
    for (int j = DEPTH - 1; j >= 0; j--) begin
      if (rot[j]) begin
        any = 1'b1;
        off = IDX_W'(j);
      end
    end
    idx   = head + off;
    grant = any ? (DEPTH'(1) << idx) : '0;
  end
endmodule

// File: rtl/giq_sizer.sv
`timescale 1ns/1ps
module giq_sizer
  import giq_pkg::*;
#(
  parameter int DEPTH        = 128,
  parameter int MIN_SIZE     = 16,
  parameter int STEP         = 8,
  parameter int WIN_CYC      = 256,
  parameter int THRESH       = 64,
  parameter int GROW_PERIODS = 4,
  localparam int SZ_W = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            commit_fire,
  input  logic [SZ_W-1:0] occ_next,
  output logic [SZ_W-1:0] eff_size,
  output logic            win_end
);
  localparam int WC_W = $clog2(WIN_CYC);
  localparam int CC_W = $clog2(WIN_CYC + 1);
  localparam int HC_W = $clog2(GROW_PERIODS + 1);

  logic [WC_W-1:0] wcnt_q;
  logic [CC_W-1:0] ccnt_q, tot;
  logic [HC_W-1:0] hcnt_q;
  logic [SZ_W-1:0] eff_q, eff_nxt;
  size_act_e       act;

  always_comb begin
    win_end = (wcnt_q == WC_W'(WIN_CYC - 1));
    tot     = ccnt_q + CC_W'(commit_fire);
    act     = SZ_HOLD;
    if (win_end) begin
      if (int'(tot) < THRESH) act = SZ_SHRINK;
      else if (hcnt_q == HC_W'(GROW_PERIODS - 1)) act = SZ_GROW;
    end
    case (act)
      SZ_SHRINK: eff_nxt = SZ_W'(shrink_size(int'(eff_q), int'(occ_next), STEP, MIN_SIZE));
      SZ_GROW:   eff_nxt = SZ_W'(grow_size(int'(eff_q), STEP, DEPTH));
      default:   eff_nxt = eff_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wcnt_q <= '0;
      ccnt_q <= '0;
      hcnt_q <= '0;
      eff_q  <= SZ_W'(DEPTH);
    end else begin
      eff_q <= eff_nxt;
      if (win_end) begin
        wcnt_q <= '0;
        ccnt_q <= '0;
        hcnt_q <= (act == SZ_HOLD) ? hcnt_q + 1'b1 : '0;
      end else begin
        wcnt_q <= wcnt_q + 1'b1;
        ccnt_q <= tot;
      end
    end
  end

  assign eff_size = eff_q;

  // R9
  still_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !win_end |=> (eff_q == $past(eff_q)));
  // R7
  floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(eff_q) >= MIN_SIZE) && (int'(eff_q) <= DEPTH));
  // R7
  shrink_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act == SZ_SHRINK) |=> (eff_q <= $past(eff_q)));
  // R8
  grow_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act == SZ_GROW) |=> (eff_q >= $past(eff_q)));
endmodule

// File: rtl/gated_issue_queue.sv
`timescale 1ns/1ps
module gated_issue_queue #(
  parameter int DEPTH        = 128,
  parameter int OP_W         = 6,
  parameter int TAG_W        = 7,
  parameter int MIN_SIZE     = 16,
  parameter int STEP         = 8,
  parameter int WIN_CYC      = 256,
  parameter int THRESH       = 64,
  parameter int GROW_PERIODS = 4,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int CMP_W = $clog2(2 * DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             disp_valid,
  input  logic [OP_W-1:0]  disp_op,
  input  logic [TAG_W-1:0] disp_dst,
  input  logic [TAG_W-1:0] disp_s1,
  input  logic             disp_r1,
  input  logic [TAG_W-1:0] disp_s2,
  input  logic             disp_r2,
  output logic             disp_ready,
  input  logic             bc_valid,
  input  logic [TAG_W-1:0] bc_tag,
  input  logic             commit,
  output logic             iss_valid,
  output logic [OP_W-1:0]  iss_op,
  output logic [TAG_W-1:0] iss_dst,
  output logic [CNT_W-1:0] q_count,
  output logic [CNT_W-1:0] eff_size,
  output logic [CMP_W-1:0] cmp_active
);
  logic [IDX_W-1:0] head_q, tail_q;
  logic [CNT_W-1:0] cnt_q, cnt_nxt;
  logic             disp_fire, commit_fire, win_end;
  logic [DEPTH-1:0] busy_v, done_v, req_v, grant;
  logic [1:0]       cmp_on_a [DEPTH];
  logic [OP_W-1:0]  slot_op  [DEPTH];
  logic [TAG_W-1:0] slot_dst [DEPTH];
  logic [IDX_W-1:0] pick_idx;
  logic             pick_any;

  assign disp_ready  = (cnt_q < eff_size);
  assign disp_fire   = disp_valid && disp_ready;
  assign commit_fire = commit && busy_v[head_q] && done_v[head_q];
  assign cnt_nxt     = cnt_q + CNT_W'(disp_fire) - CNT_W'(commit_fire);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (disp_fire)   tail_q <= tail_q + 1'b1;
      if (commit_fire) head_q <= head_q + 1'b1;
      cnt_q <= cnt_nxt;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    giq_slot #(.OP_W(OP_W), .TAG_W(TAG_W)) u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (disp_fire && (tail_q == IDX_W'(g))),
      .wr_op    (disp_op),
      .wr_dst   (disp_dst),
      .wr_s1    (disp_s1),
      .wr_r1    (disp_r1),
      .wr_s2    (disp_s2),
      .wr_r2    (disp_r2),
      .clr      (commit_fire && (head_q == IDX_W'(g))),
      .iss_set  (grant[g]),
      .bc_valid (bc_valid),
      .bc_tag   (bc_tag),
      .busy     (busy_v[g]),
      .done     (done_v[g]),
      .req      (req_v[g]),
      .cmp_on   (cmp_on_a[g]),
      .op       (slot_op[g]),
      .dst      (slot_dst[g])
    );
  end

  giq_pick #(.DEPTH(DEPTH)) u_pick (
    .req   (req_v),
    .head  (head_q),
    .any   (pick_any),
    .idx   (pick_idx),
    .grant (grant)
  );

  giq_sizer #(
    .DEPTH(DEPTH), .MIN_SIZE(MIN_SIZE), .STEP(STEP),
    .WIN_CYC(WIN_CYC), .THRESH(THRESH), .GROW_PERIODS(GROW_PERIODS)
  ) u_sizer (
    .clk         (clk),
    .rst_n       (rst_n),
    .commit_fire (commit_fire),
    .occ_next    (cnt_nxt),
    .eff_size    (eff_size),
    .win_end     (win_end)
  );

  always_comb begin
    cmp_active = '0;
    for (int i = 0; i < DEPTH; i++)
      cmp_active = cmp_active + CMP_W'(cmp_on_a[i][0]) + CMP_W'(cmp_on_a[i][1]);
  end

  assign iss_valid = pick_any;
  assign iss_op    = slot_op[pick_idx];
  assign iss_dst   = slot_dst[pick_idx];
  assign q_count   = cnt_q;

  // R2
  cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= eff_size);
  // R2
  block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !disp_ready |=> (cnt_q <= $past(cnt_q)));
  // R5
  one_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));
  // R6
  hold_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && !done_v[head_q] && !disp_fire) |=> (cnt_q == $past(cnt_q)));
  // R4
  gate_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bc_valid |-> (cmp_active == '0));
  // R9
  size_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !win_end |=> $stable(eff_size));
endmodule

// File: tb/gated_issue_queue_test.sv
`timescale 1ns/1ps
module gated_issue_queue_test;
  localparam int D = 16, OW = 4, TW = 5, MINS = 4, ST = 4, WIN = 16, TH = 4, GP = 2;
  localparam int CW = $clog2(D + 1), CMW = $clog2(2 * D + 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic disp_valid = 0, disp_r1 = 0, disp_r2 = 0, bc_valid = 0, commit = 0;
  logic [OW-1:0] disp_op = '0;
  logic [TW-1:0] disp_dst = '0, disp_s1 = '0, disp_s2 = '0, bc_tag = '0;
  logic disp_ready, iss_valid;
  logic [OW-1:0] iss_op;
  logic [TW-1:0] iss_dst;
  logic [CW-1:0] q_count, eff_size;
  logic [CMW-1:0] cmp_active;

  always #4 clk = ~clk;

  gated_issue_queue #(.DEPTH(D), .OP_W(OW), .TAG_W(TW), .MIN_SIZE(MINS), .STEP(ST),
    .WIN_CYC(WIN), .THRESH(TH), .GROW_PERIODS(GP)) uut (
    .clk(clk), .rst_n(rst_n), .disp_valid(disp_valid), .disp_op(disp_op),
    .disp_dst(disp_dst), .disp_s1(disp_s1), .disp_r1(disp_r1), .disp_s2(disp_s2),
    .disp_r2(disp_r2), .disp_ready(disp_ready), .bc_valid(bc_valid), .bc_tag(bc_tag),
    .commit(commit), .iss_valid(iss_valid), .iss_op(iss_op), .iss_dst(iss_dst),
    .q_count(q_count), .eff_size(eff_size), .cmp_active(cmp_active));

  int nchk = 0, nerr = 0;
  // reference state, indexed by slot
  bit mv[D], mi[D], mr1[D], mr2[D];
  int ms1[D], ms2[D], mop[D], mdst[D];
  int mh = 0, mt = 0, mc = 0;
  int meff = D, mw = 0, mcc = 0, mhc = 0;
  int eq_op[$], eq_dst[$];

  task automatic chk(input string what, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", what, act, exp, $time);
    end
  endtask

  // one clock cycle of stimulus, checks and reference update
  task automatic cyc(input bit dv, input int op, input int dst, input int s1, input bit r1,
                     input int s2, input bit r2, input bit bv, input int bt, input bit cm);
    int ecmp, pick, s, tot, n;
    bit erdy, df, cf;
    disp_valid = dv; disp_op = OW'(op); disp_dst = TW'(dst);
    disp_s1 = TW'(s1); disp_r1 = r1; disp_s2 = TW'(s2); disp_r2 = r2;
    bc_valid = bv; bc_tag = TW'(bt); commit = cm;
    #1;
    erdy = (mc < meff);
    chk("R2 disp_ready", int'(disp_ready), int'(erdy));
    chk("R2 R6 q_count", int'(q_count), mc);
    chk("R7 R8 R9 eff_size", int'(eff_size), meff);
    ecmp = 0;
    if (bv) for (int k = 0; k < D; k++)
      if (mv[k] && !mi[k]) ecmp += int'(!mr1[k]) + int'(!mr2[k]);
    chk("R4 cmp_active", int'(cmp_active), ecmp);
    pick = -1;
    for (int k = 0; k < mc; k++) begin
      s = (mh + k) % D;
      if (pick < 0 && mv[s] && !mi[s] && mr1[s] && mr2[s]) pick = s;
    end
    if (pick >= 0) begin eq_op.push_back(mop[pick]); eq_dst.push_back(mdst[pick]); end
    df = dv && erdy;
    cf = cm && mv[mh] && mi[mh];
    if (bv) for (int k = 0; k < D; k++) if (mv[k] && !mi[k]) begin
      if (!mr1[k] && ms1[k] == bt) mr1[k] = 1;
      if (!mr2[k] && ms2[k] == bt) mr2[k] = 1;
    end
    if (pick >= 0) mi[pick] = 1;
    if (cf) begin mv[mh] = 0; mi[mh] = 0; mh = (mh + 1) % D; end
    if (df) begin
      mv[mt] = 1; mi[mt] = 0; mop[mt] = op % (1 << OW); mdst[mt] = dst % (1 << TW);
      ms1[mt] = s1; ms2[mt] = s2; mr1[mt] = r1; mr2[mt] = r2; mt = (mt + 1) % D;
    end
    mc = mc + int'(df) - int'(cf);
    tot = mcc + int'(cf);
    if (mw == WIN - 1) begin
      mw = 0; mcc = 0;
      if (tot < TH) begin
        n = meff - ST; if (n < MINS) n = MINS; if (n < mc) n = mc;
        meff = n; mhc = 0;
      end else if (mhc == GP - 1) begin
        n = meff + ST; if (n > D) n = D; meff = n; mhc = 0;
      end else mhc++;
    end else begin
      mw++; mcc = tot;
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle(input int n, input bit cm);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, cm);
  endtask

  // monitor: compare the issue port against the predicted stream
  initial forever begin
    @(negedge clk);
    #3;
    if (rst_n && (iss_valid || eq_op.size() > 0)) begin
      if (!iss_valid) begin
        chk("R5 R3 missing issue", 0, 1);
        void'(eq_op.pop_front()); void'(eq_dst.pop_front());
      end else if (eq_op.size() == 0) begin
        chk("R5 R3 unexpected issue", 1, 0);
      end else begin
        chk("R5 iss_op", int'(iss_op), eq_op.pop_front());
        chk("R5 iss_dst", int'(iss_dst), eq_dst.pop_front());
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    chk("R1 q_count", int'(q_count), 0);
    chk("R1 eff_size", int'(eff_size), D);
    chk("R1 iss_valid", int'(iss_valid), 0);
    chk("R1 disp_ready", int'(disp_ready), 1);
    // R3 R5 R6: mixed readiness, commit against unissued head is ignored
    cyc(1, 1, 10, 3, 0, 1, 1, 0, 0, 0);
    cyc(1, 2, 11, 5, 1, 6, 1, 0, 0, 1);
    // R4: slot written with a same-cycle broadcast is not compared
    cyc(1, 3, 12, 3, 0, 4, 0, 1, 3, 0);
    idle(1, 1);
    cyc(0, 0, 0, 0, 0, 0, 0, 1, 3, 0);
    cyc(0, 0, 0, 0, 0, 0, 0, 1, 4, 0);
    // broadcast to already ready / issued operands: gated
    cyc(0, 0, 0, 0, 0, 0, 0, 1, 5, 0);
    idle(4, 1);
    // R2: fill past the limit with waiting instructions
    for (int i = 0; i < 20; i++) cyc(1, i, i + 1, 9, 0, 2, 1, 0, 0, 0);
    // R3 R5: wake them all, drain oldest first
    cyc(0, 0, 0, 0, 0, 0, 0, 1, 9, 1);
    idle(24, 1);
    // R7: quiet windows shrink the size to the floor
    idle(6 * WIN, 1);
    // R8: steady retirement grows it back
    for (int i = 0; i < 8 * WIN; i++) cyc(1, i, i % 30, 1, 1, 2, 1, 0, 0, 1);
    // R7 again: partial occupancy held as floor
    for (int i = 0; i < 6; i++) cyc(1, i, i, 7, 0, 7, 0, 0, 0, 1);
    idle(3 * WIN, 1);
    cyc(0, 0, 0, 0, 0, 0, 0, 1, 7, 1);
    idle(WIN, 1);
    chk("R5 issue stream drained", eq_op.size(), 0);
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule